// File: doc/BRIEF.md
# ADC Conversion Clock Divider Chain

This block turns a free-running peripheral clock into two single-cycle strobes for an analog-to-digital converter. One strobe marks each converter clock period. The other marks the end of each conversion. Real clock gating is out of scope: downstream logic uses the strobes as clock enables.

The chain has three stages in series:

- a fixed divide-by-two stage;
- an optional prescaler, present only in the legacy build;
- a programmable scaler.

A 32-bit clock-control word, written through a simple write port, holds both divisor fields. The parameter `LEGACY` picks the build. With `LEGACY = 1` the prescaler is present and the scaler is 10 bits wide. With `LEGACY = 0` the prescaler is absent and the scaler is 16 bits wide.

A written word is held in a shadow copy. It takes effect only when the whole chain wraps, so no converter period is ever cut short. The `run` input gates the whole chain. While `run` is low, every counter holds its value.

Top module: `adc_clk_chain`

## Requirements
- R1: With LEGACY=1, adc_tick repeats every 2*(P+1)*(S+1) running clock cycles. P is control bits [31:17] and S is control bits [9:0].
- R2: With LEGACY=0, adc_tick repeats every 2*(S+1) running clock cycles. S is control bits [15:0], and bits [31:16] have no effect.
- R3: With LEGACY=1, control bits [16:10] have no effect on the period.
- R4: adc_tick is high for exactly one clock cycle per period.
- R5: sample_tick is high on every 12th adc_tick counted from reset, and only together with an adc_tick.
- R6: A written control word takes effect only after the converter period in progress completes. The first period after reset always uses zero divisors.
- R7: While reset is asserted, both outputs are low. After reset the first adc_tick comes only after one full period.
- R8: While run is low, no strobe is produced and the counters hold. Counting resumes from the held state when run returns high.
- R9: With all divisor fields zero, the period is 2 cycles, set by the fixed divide-by-two stage alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables counting; the counters hold when low |
| cfg_we | input | 1 | Write strobe for the clock-control word |
| cfg_wdata | input | 32 | Clock-control word (prescaler [31:17], scaler from bit 0) |
| adc_tick | output | 1 | One-cycle converter clock enable |
| sample_tick | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The embedded properties check the following on every cycle:

- adc_tick is one cycle wide;
- sample_tick is only ever high alongside adc_tick;
- run low means no strobe and frozen counters;
- both outputs stay low in reset;
- the active divisors change only on a wrap;
- the scaler count stays within its divisor.

The exact period lengths can only be shown by the bench's scenarios, which run both builds side by side against a queue of expected intervals. These scenarios cover:

- the product formula;
- which control bits each build ignores;
- the deferred reload after a write in mid-run;
- the twelve-tick spacing of the sample strobe.

// File: rtl/adc_clk_chain.sv
module adc_clk_chain #(
  parameter bit LEGACY    = 1'b1,
  parameter int PRE_W     = 15,
  parameter int PRE_LSB   = 17,
  parameter int SC_W_OLD  = 10,
  parameter int SC_W_NEW  = 16,
  parameter int CONV_CLKS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        adc_tick,
  output logic        sample_tick
);
  localparam int SC_W = LEGACY ? SC_W_OLD : SC_W_NEW;
  localparam int CW   = $clog2(CONV_CLKS);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CLKS - 1);

  logic            half;
  logic            pre_t;
  logic            sc_t;
  logic            step;
  logic            wrap;
  logic [SC_W-1:0] sc_sh, sc_act, sc_cnt;
  logic [CW-1:0]   conv_cnt;

  assign step = run & half;
  assign sc_t = (sc_cnt == sc_act);
  assign wrap = step & pre_t & sc_t;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   half <= 1'b0;
    else if (run) half <= ~half;

  generate
    if (LEGACY) begin : g_pre
      logic [PRE_W-1:0] pre_sh, pre_act, pre_cnt;
      assign pre_t = (pre_cnt == pre_act);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          pre_sh  <= '0;
          pre_act <= '0;
          pre_cnt <= '0;
        end else begin
          if (cfg_we) pre_sh  <= cfg_wdata[PRE_LSB +: PRE_W];
          if (wrap)   pre_act <= pre_sh;
          if (step)   pre_cnt <= pre_t ? '0 : pre_cnt + 1'b1;
        end

      AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pre_act) |-> adc_tick); // R6
    end else begin : g_nopre
      assign pre_t = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sc_sh  <= '0;
      sc_act <= '0;
      sc_cnt <= '0;
    end else begin
      if (cfg_we)       sc_sh  <= cfg_wdata[SC_W-1:0];
      if (wrap)         sc_act <= sc_sh;
      if (step & pre_t) sc_cnt <= sc_t ? '0 : sc_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      conv_cnt    <= '0;
      adc_tick    <= 1'b0;
      sample_tick <= 1'b0;
    end else begin
      adc_tick    <= wrap;
      sample_tick <= wrap & (conv_cnt == CONV_LAST);
      if (wrap) conv_cnt <= (conv_cnt == CONV_LAST) ? '0 : conv_cnt + 1'b1;
    end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !adc_tick && !sample_tick); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !adc_tick); // R8
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(sc_cnt) && $stable(half) && $stable(conv_cnt)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |=> !adc_tick); // R4
  AST_SAMPLE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> adc_tick); // R5
  AST_SC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sc_act) |-> adc_tick); // R6
  AST_SC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sc_cnt <= sc_act); // R1
endmodule

// File: tb/adc_clk_chain_tb.sv
module adc_clk_chain_tb;
  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic has0 = 1'b0, has1 = 1'b0, en0 = 1'b0, en1 = 1'b0, ptk0 = 1'b0, ptk1 = 1'b0;
  logic run0, run1, tk0, st0, tk1, st1;
  int q0[$], q1[$];
  int checks = 0, errors = 0, cnt0 = 0, cnt1 = 0, nt0 = 0, nt1 = 0, cyc = 0;
  bit wd = 1'b0;

  assign run0 = go & has0;
  assign run1 = go & has1;

  always #2 clk = ~clk;

  adc_clk_chain #(.LEGACY(1'b1)) u_dut (.clk(clk), .rst_n(rst_n), .run(run0),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .adc_tick(tk0), .sample_tick(st0));
  adc_clk_chain #(.LEGACY(1'b0)) u_dut_new (.clk(clk), .rst_n(rst_n), .run(run1),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .adc_tick(tk1), .sample_tick(st1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon(input logic tk, input logic st, input logic en, ref int q[$],
                     ref int cnt, ref int nt, ref logic ptk, ref logic has);
    int e;
    if (!rst_n) begin
      cnt = 0; nt = 0; ptk = 1'b0;
    end else begin
      if (en) cnt++;
      if (tk) begin
        check(en, "R8 tick only while running", 0, 1);
        check(!ptk, "R4 single-cycle tick", int'(ptk), 0);
        nt++;
        if (q.size() == 0) check(1'b0, "R6 unexpected tick", cnt, 0);
        else begin
          e = q.pop_front();
          check(cnt == e, "R1 R2 R3 R6 R9 period", cnt, e);
        end
        check(st == (nt % 12 == 0), "R5 sample strobe", int'(st), int'(nt % 12 == 0));
        cnt = 0;
      end else if (st) check(1'b0, "R5 strobe without tick", 1, 0);
      ptk = tk;
    end
    has = (q.size() != 0);
  endtask

  always @(posedge clk) begin
    en0 <= run0;
    en1 <= run1;
  end

  always @(negedge clk) begin
    mon(tk0, st0, en0, q0, cnt0, nt0, ptk0, has0);
    mon(tk1, st1, en1, q1, cnt1, nt1, ptk1, has1);
    cyc++;
    if (cyc > 150000 && !wd) begin
      wd = 1'b1;
      check(1'b0, "watchdog", cyc, 150000);
    end
  end

  task automatic do_reset();
    go = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!tk0 && !st0 && !tk1 && !st1, "R7 outputs low in reset", int'(tk0 | tk1), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tk0 && !tk1, "R7 quiet before run", int'(tk0 | tk1), 0);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int l, input int n, input int nl);
    for (int i = 0; i < nl; i++) begin
      q0.push_back(l);
      q1.push_back(n);
    end
  endtask

  task automatic drain();
    while ((q0.size() != 0 || q1.size() != 0) && !wd) @(negedge clk);
    go = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R9, R5: zero divisors, 26 ticks of 2 cycles, strobes at ticks 12 and 24
    do_reset();
    wr(32'h0);
    push(2, 2, 26);
    go = 1'b1;
    drain();

    // R1, R2, R6: prescaler 2, scaler 3; first period still uses zero divisors
    do_reset();
    wr((32'd2 << 17) | 32'd3);
    push(2, 2, 1);
    push(24, 8, 3);
    go = 1'b1;
    drain();

    // R3: bit 10 ignored by legacy scaler, used by 16-bit scaler; R2 prescaler ignored
    do_reset();
    wr((32'd1 << 17) | (32'd1 << 10) | 32'd5);
    push(2, 2, 1);
    push(24, 2060, 2);
    go = 1'b1;
    drain();

    // R8 freeze, then R6 mid-run rewrite
    do_reset();
    wr(32'd4);
    push(2, 2, 1);
    push(10, 10, 4);
    push(12, 6, 2);
    go = 1'b1;
    while (nt0 < 2 && !wd) @(negedge clk);
    repeat (3) @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check(!tk0 && !tk1, "R8 no tick while frozen", int'(tk0 | tk1), 0);
    end
    go = 1'b1;
    while (nt0 < 4 && !wd) @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = (32'd1 << 17) | 32'd2;
    @(negedge clk);
    cfg_we = 1'b0;
    drain();
    check(q0.size() == 0 && q1.size() == 0, "R6 all periods seen", q0.size() + q1.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule